// File: doc/BRIEF.md
# Two-Decade Rate Multiplier

This block divides a 100-slot frame into a programmed number of output pulses. A clock enable input marks the slots: each enabled cycle advances a two-digit decimal position counter from 00 to 99 and back to 00. The program is a two-digit decimal number from 0 to 99, given as a tens digit and a units digit. In every frame the block produces exactly that many single-cycle pulses. The pulses are interleaved across the frame rather than bunched together. Downstream, each pulse asks a prescaler controller for one extra division cycle, so the block sets the fractional part of a division ratio in steps of one hundredth.

The tens digit controls the slots whose units position is 1 to 9. It produces tens-digit pulses in each run of ten slots, spread evenly over that run. The units digit controls only the slots whose units position is 0, one per run of ten, so the two digits never claim the same slot. The program is sampled once per frame, on the step from 99 back to 00. Each pulse is decided one enabled slot early and held in a register, then released in its own slot.

Top module: `two_decade_rate_mult`

## Requirements
- R1: The program value is 10 × tens digit + units digit, giving 0 to 99 pulses per frame.
- R2: Each frame of 100 enabled cycles carries exactly as many pulses as the program value in force for that frame.
- R3: At a position with units digit u from 1 to 9, a pulse occurs when floor((u+1)·T/10) differs from floor(u·T/10), where T is the tens digit of the program.
- R4: At a position with units digit 0 and tens digit t, a pulse occurs when floor((t+1)·U/10) differs from floor(t·U/10), where U is the units digit of the program. No pulse ever occurs at position 00.
- R5: Tens-digit pulses and units-digit pulses never fall in the same slot, so a program of 99 gives 99 distinct pulses.
- R6: The decision for a slot is registered on the enabled cycle before that slot. For example, the pulse at position 30 is prepared on the enabled cycle at position 29.
- R7: The digit inputs are sampled only on the enabled cycle at position 99, and the sampled values take effect from position 00 of the next frame. Changes at any other time have no effect.
- R8: After reset the position is 00, the program in force is 0, and both outputs are low, so the first frame has no pulses.
- R9: A digit input above 9 is treated as 9.
- R10: frame_o is high for exactly one cycle per frame: the enabled cycle at position 00.
- R11: Both outputs are low in any cycle where en_i is low, and such cycles do not advance the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Slot enable; one cycle per frame slot |
| tens_i | input | 4 | Tens digit of the program (BCD; values above 9 are treated as 9) |
| units_i | input | 4 | Units digit of the program (BCD; values above 9 are treated as 9) |
| pulse_o | output | 1 | Rate-multiplied pulse, one cycle long |
| frame_o | output | 1 | Frame marker, high on the enabled cycle at position 00 |

## Verification
The programs used are 0, 99, 1, 10, 50, 73, 29 and 95, along with non-BCD digit pairs. A program of 0 confirms that no slot fires by default. A program of 99 shows that the two digit groups stay apart. The programs 1 and 10 exercise one digit at a time: 1 fires a single slot at a units-zero boundary, and 10 fires one slot in every run of ten. The mixed values check the exact slot positions and that the per-frame totals add up. Each frame is run both with the enable high on every cycle and with the enable idle for a varying number of cycles between slots, which shows that idle cycles neither advance the position nor emit pulses. Garbage digits are driven on every slot except position 99, which shows that the program is taken only at the frame wrap.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    localparam int DIGIT_W   = 4;
    localparam int RADIX     = 10;
    localparam int NUM_DEC   = 2;
    localparam int FRAME_LEN = RADIX ** NUM_DEC;
    localparam int PCNT_W    = $clog2(FRAME_LEN + 1);

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } bcd2_t;

    typedef enum logic [0:0] {
        SRC_TENS  = 1'b0,
        SRC_UNITS = 1'b1
    } slot_src_e;

    function automatic digit_t clamp_digit(input digit_t d);
        return (d > digit_t'(RADIX - 1)) ? digit_t'(RADIX - 1) : d;
    endfunction

    // Spreads 'rate' hits evenly over the RADIX positions of one decade.
    function automatic logic slot_hit(input digit_t rate, input digit_t pos);
        int lo;
        int hi;
        lo = (int'(pos) * int'(rate)) / RADIX;
        hi = ((int'(pos) + 1) * int'(rate)) / RADIX;
        return (hi != lo);
    endfunction

    function automatic logic [PCNT_W-1:0] bcd2_value(input bcd2_t v);
        return PCNT_W'(int'(v.tens) * RADIX + int'(v.units));
    endfunction

endpackage

// File: rtl/rmul_decade.sv
module rmul_decade
    import rmul_pkg::*;
#(
    parameter int MAXV = RADIX - 1
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   step_i,
    output digit_t q_o,
    output digit_t nxt_o,
    output logic   carry_o
);

    digit_t q_r;
    logic   at_top;

    assign at_top  = (q_r == digit_t'(MAXV));
    assign nxt_o   = at_top ? '0 : q_r + digit_t'(1);
    assign carry_o = step_i & at_top;
    assign q_o     = q_r;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_r <= '0;
        end else if (step_i) begin
            q_r <= nxt_o;
        end
    end

endmodule

// File: rtl/rmul_slot_decode.sv
module rmul_slot_decode
    import rmul_pkg::*;
(
    input  bcd2_t pos_i,
    input  bcd2_t prog_i,
    output logic  hit_o
);

    slot_src_e src;

    always_comb begin
        src = (pos_i.units == '0) ? SRC_UNITS : SRC_TENS;
        unique case (src)
            SRC_UNITS: hit_o = slot_hit(prog_i.units, pos_i.tens);
            SRC_TENS:  hit_o = slot_hit(prog_i.tens, pos_i.units);
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/two_decade_rate_mult.sv
module two_decade_rate_mult
    import rmul_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [DIGIT_W-1:0] tens_i,
    input  logic [DIGIT_W-1:0] units_i,
    output logic               pulse_o,
    output logic               frame_o
);

    digit_t pos_q  [NUM_DEC];
    digit_t pos_nx [NUM_DEC];
    digit_t pos_adv[NUM_DEC];
    logic   step   [NUM_DEC];
    logic   carry  [NUM_DEC];

    genvar g;
    generate
        for (g = 0; g < NUM_DEC; g++) begin : g_dec
            if (g == 0) begin : g_first
                assign step[g] = en_i;
            end else begin : g_chain
                assign step[g] = carry[g-1];
            end

            rmul_decade #(.MAXV(RADIX - 1)) i_decade (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .step_i (step[g]),
                .q_o    (pos_q[g]),
                .nxt_o  (pos_nx[g]),
                .carry_o(carry[g])
            );

            assign pos_adv[g] = step[g] ? pos_nx[g] : pos_q[g];
        end
    endgenerate

    bcd2_t prog_q;
    bcd2_t prog_in;
    bcd2_t prog_use;
    bcd2_t pos_cur;
    bcd2_t pos_next;
    logic  wrap;
    logic  hit_next;
    logic  arm_q;

    assign wrap     = carry[NUM_DEC-1];
    assign prog_in  = '{tens: clamp_digit(tens_i), units: clamp_digit(units_i)};
    assign prog_use = wrap ? prog_in : prog_q;
    assign pos_cur  = '{tens: pos_q[1], units: pos_q[0]};
    assign pos_next = '{tens: pos_adv[1], units: pos_adv[0]};

    // Decision for the upcoming slot, prepared one enabled slot ahead.
    rmul_slot_decode i_decode (
        .pos_i (pos_next),
        .prog_i(prog_use),
        .hit_o (hit_next)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prog_q <= '0;
            arm_q  <= 1'b0;
        end else if (en_i) begin
            arm_q <= hit_next;
            if (wrap) begin
                prog_q <= prog_in;
            end
        end
    end

    assign pulse_o = en_i & arm_q;
    assign frame_o = en_i & (pos_cur == '0);

endmodule

// File: rtl/rmul_checker.sv
module rmul_checker
    import rmul_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic               en_i,
    input logic [DIGIT_W-1:0] tens_i,
    input logic [DIGIT_W-1:0] units_i,
    input logic               pulse_o,
    input logic               frame_o
);

    logic [PCNT_W:0]   en_cnt;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] last_prog;
    logic [PCNT_W-1:0] cur_exp;
    logic              seen;
    bcd2_t             samp;

    assign samp = '{tens: clamp_digit(tens_i), units: clamp_digit(units_i)};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_cnt    <= '0;
            pcnt      <= '0;
            last_prog <= '0;
            cur_exp   <= '0;
            seen      <= 1'b0;
        end else if (en_i) begin
            last_prog <= bcd2_value(samp);
            if (frame_o) begin
                en_cnt  <= (PCNT_W+1)'(1);
                pcnt    <= PCNT_W'(pulse_o);
                cur_exp <= last_prog;
                seen    <= 1'b1;
            end else begin
                en_cnt <= en_cnt + (PCNT_W+1)'(1);
                pcnt   <= pcnt + PCNT_W'(pulse_o);
            end
        end
    end

    // R11: outputs only in enabled cycles
    assert_pulse_needs_en_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> en_i);
    assert_frame_needs_en_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |-> en_i);
    // R10: frame marker every 100 enabled slots
    assert_frame_period_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_o && seen) |-> (en_cnt == (PCNT_W+1)'(FRAME_LEN)));
    // R2: pulses per frame equal the program in force
    assert_frame_count_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (frame_o && seen) |-> (pcnt == cur_exp));
    // R4: position 00 never carries a pulse
    assert_no_pulse_at_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pulse_o && frame_o));

endmodule

bind two_decade_rate_mult rmul_checker i_rmul_checker (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .tens_i (tens_i),
    .units_i(units_i),
    .pulse_o(pulse_o),
    .frame_o(frame_o)
);

// File: tb/test_two_decade_rate_mult.sv
`timescale 1ns/1ps
module test_two_decade_rate_mult;

    localparam int NFR = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [3:0] tens;
    logic [3:0] units;
    logic       pulse;
    logic       frame;

    int vectors = 0;
    int errors  = 0;
    int tally   = 0;

    typedef struct {
        bit    pulse;
        bit    frame;
        bit    last;
        int    total;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    two_decade_rate_mult i_two_decade_rate_mult (
        .clk_i  (clk),
        .rst_i  (rst),
        .en_i   (en),
        .tens_i (tens),
        .units_i(units),
        .pulse_o(pulse),
        .frame_o(frame)
    );

    function automatic int clampd(input int d);
        return (d > 9) ? 9 : d;
    endfunction

    // Slot rule from R3 and R4
    function automatic bit exp_hit(input int t_d, input int u_d, input int c);
        int u = c % 10;
        int t = c / 10;
        if (u == 0) return (((t + 1) * u_d) / 10) != ((t * u_d) / 10);
        return (((u + 1) * t_d) / 10) != ((u * t_d) / 10);
    endfunction

    // Monitor: pops expected slot items and compares
    always @(negedge clk) begin
        #1.5;
        if (!rst) begin
            if (en) begin
                exp_t it;
                vectors++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R2: unexpected enabled slot, actual pulse=%0b expected none", pulse);
                end else begin
                    it = sb.pop_front();
                    if (pulse !== it.pulse) begin
                        errors++;
                        $display("FAIL %s: pulse actual=%0b expected=%0b", it.tag, pulse, it.pulse);
                    end
                    if (frame !== it.frame) begin
                        errors++;
                        $display("FAIL R10: frame actual=%0b expected=%0b", frame, it.frame);
                    end
                    tally += int'(pulse);
                    if (it.last) begin
                        vectors++;
                        if (tally != it.total) begin
                            errors++;
                            $display("FAIL R1 R2: pulses per frame actual=%0d expected=%0d", tally, it.total);
                        end
                        tally = 0;
                    end
                end
            end else begin
                vectors++;
                if (pulse !== 1'b0 || frame !== 1'b0) begin
                    errors++;
                    $display("FAIL R11: idle outputs actual=%0b%0b expected=00", pulse, frame);
                end
            end
        end
    end

    int raw_t[NFR] = '{7, 0, 9, 0, 1, 5, 15, 10, 2, 0};
    int raw_u[NFR] = '{3, 0, 9, 1, 0, 0, 12, 5, 9, 0};

    task automatic run_frame(input int f);
        int et = (f == 0) ? 0 : clampd(raw_t[f-1]);
        int eu = (f == 0) ? 0 : clampd(raw_u[f-1]);
        int tot = et * 10 + eu;
        for (int c = 0; c < 100; c++) begin
            exp_t it;
            int gap = (f % 2 == 1) ? (c % 3) : 0;
            for (int k = 0; k < gap; k++) begin
                @(negedge clk);
                en    = 1'b0;
                tens  = 4'(~raw_t[f]);
                units = 4'(~raw_u[f]);
            end
            it.pulse = exp_hit(et, eu, c);
            it.frame = (c == 0);
            it.last  = (c == 99);
            it.total = tot;
            if (f == 0)                          it.tag = "R8";
            else if (f == 7 || f == 8)           it.tag = "R9 R7";
            else if (c == 30)                    it.tag = "R6 R4";
            else if (c % 10 == 0 && et == 9)     it.tag = "R4 R5";
            else if (c % 10 == 0)                it.tag = "R4 R7";
            else                                 it.tag = "R3 R7";
            sb.push_back(it);
            @(negedge clk);
            en = 1'b1;
            // R7: only the slot at position 99 carries the real program
            if (c == 99) begin
                tens  = 4'(raw_t[f]);
                units = 4'(raw_u[f]);
            end else begin
                tens  = 4'(~raw_t[f]);
                units = 4'(~raw_u[f]);
            end
        end
    endtask

    initial begin
        rst   = 1'b1;
        en    = 1'b0;
        tens  = 4'd7;
        units = 4'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1.5;
        vectors++;
        if (pulse !== 1'b0 || frame !== 1'b0) begin
            errors++;
            $display("FAIL R8: reset outputs actual=%0b%0b expected=00", pulse, frame);
        end
        for (int f = 0; f < NFR; f++) run_frame(f);
        @(negedge clk);
        en = 1'b0;
        repeat (4) @(negedge clk);
        vectors++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2: items left actual=%0d expected=0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R2: watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule